// File: doc/BRIEF.md
# I2C Master Command Engine

This block is the bus-condition and single-byte core of an I2C master. Software talks to it through four byte-wide registers on a simple write-strobe bus with a combinational read port. Writing the control register with the enable bit set and a command makes the engine put a START, a repeated START or a STOP on the bus. Writing the data register shifts one byte out on SDA and captures the target's acknowledge. SCL and SDA are driven open-drain style: an output enable of 1 pulls the line low, and 0 releases it.

Every action is built from quarter-bit phases of `QUARTER_CYC` clock cycles each. A busy bit is high for as long as an action runs. A session-done flag is set when the action ends, and it can raise the interrupt line. A write to the control or data register while busy is refused and sets an error flag. After each action, software normally writes back the no-action command with enable kept at 1.

Register map (byte addresses on `reg_addr`): 0 control, 1 data, 2 status, 3 interrupt enable.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe` and `irq` are 0, and the control register (address 0) and status register (address 2) both read 0x00.
- R2: Writing control with bit 0 = 1, bits 2:1 = 1 and bit 3 = 0 gives a START. SDA falls while SCL is high, and the engine ends with both lines held low.
- R3: Writing control with bit 0 = 1, bits 2:1 = 1 and bit 3 = 1 gives a repeated START. SDA is released while SCL is low, SCL is released, and then SDA falls while SCL is high. The engine ends with both lines low.
- R4: Writing control with bit 0 = 1 and bits 2:1 = 2 gives a STOP. SDA rises while SCL is high, and afterwards both lines are released.
- R5: Writing the data register (address 1) while enabled sends the byte MSB first over 9 SCL pulses, with SDA released on the ninth. SDA is sampled during the ninth high phase. Control bit 3 then reads 1 for NAK and 0 for ACK.
- R6: Status bit 7 (busy) reads 1 from the cycle after an accepted command or data write until the action ends. While the engine is idle and no register is written, the bus outputs do not change.
- R7: When an action ends, status bit 3 (done) is set. `irq` equals that flag ANDed with interrupt-enable bit 3 (address 3).
- R8: Writing 1 to status bit 3 or bit 2 clears that flag. Writing any other status bit has no effect.
- R9: A write to the control or data register while busy is ignored and sets status bit 2 (error).
- R10: A control write with bit 0 = 0, or with command 0 or 3, starts no bus action and sets no flag. A data write while enable is 0 is ignored. Control bits 2:0 read back as written.
- R11: In each bit of a byte, SCL stays high for 2 x `QUARTER_CYC` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 data, 2 status, 3 interrupt enable) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Session-done interrupt |

## Verification
The bench writes control with the enable bit cleared, with command 0 and with command 3, and expects a silent bus. A decoder that ignored enable or treated command 3 as STOP would produce edges and a done flag. It sends bytes whose most significant bits differ and answers both ACK and NAK. Reversed bit order or a NAK sampled on the wrong phase would show up as a wrong captured byte or a wrong control bit 3. It issues a second data write while a byte is still in flight. A design that accepted that write would corrupt the byte on the bus, and one that dropped it silently would leave the error flag clear. It also writes reserved status bits while done is set, and writes the error bit alone. A clear-on-any-write flag would lose the done bit.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    localparam int unsigned DW = 8;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_DATA = 2'd1;
    localparam logic [1:0] ADR_STAT = 2'd2;
    localparam logic [1:0] ADR_IEN  = 2'd3;

    localparam int unsigned CT_EN   = 0;
    localparam int unsigned CT_ACK  = 3;
    localparam int unsigned ST_BUSY = 7;
    localparam int unsigned ST_DONE = 3;
    localparam int unsigned ST_ERR  = 2;
    localparam int unsigned IE_DONE = 3;

    localparam logic [1:0] CMD_NONE = 2'd0;
    localparam logic [1:0] CMD_COND = 2'd1;
    localparam logic [1:0] CMD_STOP = 2'd2;

    localparam logic [3:0] ACK_BIT_IDX = 4'd8;

    typedef enum logic [2:0] {
        OP_IDLE, OP_START, OP_RSTART, OP_STOP, OP_BYTE
    } op_e;

    typedef struct packed {
        op_e          op;
        logic [1:0]   step;
        logic [3:0]   bitn;
        logic [DW-1:0] sh;
        logic         scl_low;
        logic         sda_low;
        logic         done;
        logic         nak;
        logic         nak_upd;
    } seq_t;

    typedef struct packed {
        logic       en;
        logic [1:0] cmd;
        logic       nak;
        logic       done;
        logic       err;
        logic       ien;
    } regs_t;

    // Final quarter-phase index of each action.
    function automatic logic [1:0] last_step(op_e op);
        case (op)
            OP_RSTART, OP_BYTE: last_step = 2'd3;
            default:            last_step = 2'd2;
        endcase
    endfunction

    // Line levels {scl_low, sda_low} for an action at a given quarter phase.
    function automatic logic [1:0] bus_lv(op_e op, logic [1:0] step,
                                          logic bitv, logic ackb);
        case (op)
            OP_START: case (step)
                2'd0:    bus_lv = 2'b00;
                2'd1:    bus_lv = 2'b01;
                default: bus_lv = 2'b11;
            endcase
            OP_RSTART: case (step)
                2'd0:    bus_lv = 2'b10;
                2'd1:    bus_lv = 2'b00;
                2'd2:    bus_lv = 2'b01;
                default: bus_lv = 2'b11;
            endcase
            OP_STOP: case (step)
                2'd0:    bus_lv = 2'b11;
                2'd1:    bus_lv = 2'b01;
                default: bus_lv = 2'b00;
            endcase
            OP_BYTE: bus_lv = {(step == 2'd0) || (step == 2'd3),
                               ackb ? 1'b0 : ~bitv};
            default: bus_lv = 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/i2c_cmd_tick.sv
module i2c_cmd_tick #(
    parameter int unsigned QUARTER_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (QUARTER_CYC > 2) ? $clog2(QUARTER_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUARTER_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
    import i2c_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  op_e           go_op,
    input  logic [DW-1:0] go_data,
    input  logic          tick,
    input  logic          sda_in,
    output logic          busy,
    output logic          done,
    output logic          nak,
    output logic          nak_upd,
    output logic          scl_oe,
    output logic          sda_oe
);
    seq_t q, d;
    logic last;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.nak_upd = 1'b0;
        last      = (q.step == last_step(q.op)) &&
                    ((q.op != OP_BYTE) || (q.bitn == ACK_BIT_IDX));
        if (q.op == OP_IDLE) begin
            if (go) begin
                d.op   = go_op;
                d.step = 2'd0;
                d.bitn = 4'd0;
                d.sh   = go_data;
                {d.scl_low, d.sda_low} = bus_lv(go_op, 2'd0, go_data[DW-1], 1'b0);
            end
        end else if (tick) begin
            if ((q.op == OP_BYTE) && (q.bitn == ACK_BIT_IDX) && (q.step == 2'd1))
                d.nak = sda_in;
            if (last) begin
                d.op      = OP_IDLE;
                d.done    = 1'b1;
                d.nak_upd = (q.op == OP_BYTE);
            end else begin
                d.step = q.step + 2'd1;
                if ((q.op == OP_BYTE) && (q.step == 2'd3)) begin
                    d.bitn = q.bitn + 4'd1;
                    d.sh   = {q.sh[DW-2:0], 1'b0};
                end
                {d.scl_low, d.sda_low} = bus_lv(q.op, d.step, d.sh[DW-1],
                                                d.bitn == ACK_BIT_IDX);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{op: OP_IDLE, default: '0};
        else        q <= d;
    end

    assign busy    = (q.op != OP_IDLE);
    assign done    = q.done;
    assign nak     = q.nak;
    assign nak_upd = q.nak_upd;
    assign scl_oe  = q.scl_low;
    assign sda_oe  = q.sda_low;
endmodule

// File: rtl/i2c_cmd_regs.sv
module i2c_cmd_regs
    import i2c_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          busy,
    input  logic          seq_done,
    input  logic          seq_nak,
    input  logic          seq_nak_upd,
    output logic          go,
    output op_e           go_op,
    output logic [DW-1:0] go_data,
    output logic          irq,
    output logic          err_flag,
    output logic          ien_flag
);
    regs_t q, d;
    logic ctrl_wr, data_wr, stat_wr, ien_wr;

    always_comb begin
        ctrl_wr = reg_we && (reg_addr == ADR_CTRL);
        data_wr = reg_we && (reg_addr == ADR_DATA);
        stat_wr = reg_we && (reg_addr == ADR_STAT);
        ien_wr  = reg_we && (reg_addr == ADR_IEN);
        d       = q;
        go      = 1'b0;
        go_op   = OP_IDLE;
        go_data = reg_wdata;

        if (stat_wr) begin
            if (reg_wdata[ST_DONE]) d.done = 1'b0;
            if (reg_wdata[ST_ERR])  d.err  = 1'b0;
        end
        if (ien_wr) d.ien = reg_wdata[IE_DONE];

        if ((ctrl_wr || data_wr) && busy) begin
            d.err = 1'b1;
        end else if (ctrl_wr) begin
            d.en  = reg_wdata[CT_EN];
            d.cmd = reg_wdata[2:1];
            if (reg_wdata[CT_EN]) begin
                if (reg_wdata[2:1] == CMD_COND) begin
                    go    = 1'b1;
                    go_op = reg_wdata[CT_ACK] ? OP_RSTART : OP_START;
                end else if (reg_wdata[2:1] == CMD_STOP) begin
                    go    = 1'b1;
                    go_op = OP_STOP;
                end
            end
        end else if (data_wr && q.en) begin
            go    = 1'b1;
            go_op = OP_BYTE;
        end

        if (seq_nak_upd) d.nak  = seq_nak;
        if (seq_done)    d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            ADR_CTRL: reg_rdata = {4'b0, q.nak, q.cmd, q.en};
            ADR_STAT: reg_rdata = {busy, 3'b0, q.done, q.err, 2'b0};
            ADR_IEN:  reg_rdata = {4'b0, q.ien, 3'b0};
            default:  reg_rdata = '0;
        endcase
    end

    assign irq      = q.done && q.ien;
    assign err_flag = q.err;
    assign ien_flag = q.ien;
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
    import i2c_cmd_pkg::*;
#(
    parameter int unsigned QUARTER_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       irq
);
    logic          busy_w, done_w, nak_w, nak_upd_w, tick_w, go_w, err_w, ien_w;
    op_e           go_op_w;
    logic [DW-1:0] go_data_w;

    i2c_cmd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy_w),
        .seq_done(done_w), .seq_nak(nak_w), .seq_nak_upd(nak_upd_w),
        .go(go_w), .go_op(go_op_w), .go_data(go_data_w), .irq(irq),
        .err_flag(err_w), .ien_flag(ien_w)
    );

    i2c_cmd_tick #(.QUARTER_CYC(QUARTER_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy_w), .tick(tick_w)
    );

    i2c_cmd_seq u_seq (
        .clk(clk), .rst_n(rst_n), .go(go_w), .go_op(go_op_w), .go_data(go_data_w),
        .tick(tick_w), .sda_in(sda_in), .busy(busy_w), .done(done_w),
        .nak(nak_w), .nak_upd(nak_upd_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );
endmodule

// File: rtl/i2c_cmd_engine_chk.sv
module i2c_cmd_engine_chk
    import i2c_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [1:0] reg_addr,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       irq,
    input logic       busy,
    input logic       seq_done,
    input logic       err_flag,
    input logic       ien_flag
);
    // R6: an idle engine with no register write leaves the bus alone
    assert_quiet_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !reg_we) |=> ($stable(scl_oe) && $stable(sda_oe)));

    // R6: busy only starts after a register write
    assert_busy_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we));

    // R7: the end of busy coincides with the session-done pulse
    assert_done_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> seq_done);

    // R7: an enabled done pulse reaches the interrupt line
    assert_irq_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && ien_flag && !(reg_we && reg_addr == ADR_IEN)) |=> irq);

    // R9: a busy-time write to control or data flags an error
    assert_err_on_busy_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && busy && (reg_addr == ADR_CTRL || reg_addr == ADR_DATA)) |=> err_flag);
endmodule

bind i2c_cmd_engine i2c_cmd_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq), .busy(busy_w),
    .seq_done(done_w), .err_flag(err_w), .ien_flag(ien_w)
);

// File: tb/test_i2c_cmd_engine.sv
module test_i2c_cmd_engine;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sda_in, scl_oe, sda_oe, irq;

    logic tgt_low = 1'b0;
    logic ack_mode = 1'b1;
    logic mon_clr = 1'b0;
    int   starts = 0, stops = 0, rises = 0, falls = 0, hi_cnt = 0, last_hi = 0;
    logic [8:0] cap = '0;
    logic prev_scl = 1'b1, prev_sda = 1'b1;

    int nchk = 0, nfail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign sda_in = !(sda_oe || tgt_low);

    i2c_cmd_engine #(.QUARTER_CYC(Q)) i_i2c_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
    );

    // Bus monitor and target model
    always @(negedge clk) begin
        logic scl, sda;
        scl = !scl_oe;
        sda = sda_in;
        if (mon_clr) begin
            starts = 0; stops = 0; rises = 0; falls = 0; cap = '0;
            hi_cnt = 0; last_hi = 0; tgt_low = 1'b0;
        end else begin
            if (prev_scl && scl && prev_sda && !sda) starts++;
            if (prev_scl && scl && !prev_sda && sda) stops++;
            if (!prev_scl && scl) begin
                cap = {cap[7:0], sda}; rises++; hi_cnt = 1;
            end else if (scl) hi_cnt++;
            if (prev_scl && !scl) begin
                falls++; last_hi = hi_cnt;
                if (falls == 8) tgt_low = ack_mode;
                if (falls == 9) tgt_low = 1'b0;
            end
        end
        prev_scl = scl;
        prev_sda = sda;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic clr_mon();
        #1 mon_clr = 1'b1;
        @(negedge clk);
        #1 mon_clr = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] s;
        bit gone = 0;
        for (int i = 0; i < 4000; i++) begin
            rd(2'd2, s);
            if (!s[7]) begin gone = 1; break; end
        end
        chk(gone, {req, " busy timeout"}, 1, 0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk(scl_oe == 0 && sda_oe == 0, "R1 bus released", {scl_oe, sda_oe}, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        rd(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 0);
        rd(2'd2, v); chk(v == 8'h00, "R1 stat", v, 0);
    endtask

    task automatic t_no_action();
        logic [7:0] v;
        clr_mon();
        wr(2'd0, 8'h02);
        repeat (40) @(negedge clk);
        rd(2'd2, v); chk(v == 8'h00, "R10 en=0 cmd=1 stat", v, 0);
        wr(2'd0, 8'h01);
        repeat (40) @(negedge clk);
        rd(2'd2, v); chk(v == 8'h00, "R10 cmd=0 stat", v, 0);
        wr(2'd0, 8'h07);
        repeat (40) @(negedge clk);
        rd(2'd2, v); chk(v == 8'h00, "R10 cmd=3 stat", v, 0);
        rd(2'd0, v); chk(v == 8'h07, "R10 ctrl readback", v, 8'h07);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hC3);
        repeat (60) @(negedge clk);
        rd(2'd2, v); chk(v == 8'h00, "R10 data while disabled stat", v, 0);
        chk(rises == 0 && starts == 0 && stops == 0, "R10 bus silent",
            rises + starts + stops, 0);
        chk(scl_oe == 0 && sda_oe == 0, "R10 lines released", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_start();
        logic [7:0] v;
        clr_mon();
        wr(2'd0, 8'h03);
        rd(2'd2, v); chk(v[7] == 1'b1, "R6 busy after start write", v[7], 1);
        wait_idle("R2");
        chk(starts == 1, "R2 start seen", starts, 1);
        chk(scl_oe == 1 && sda_oe == 1, "R2 lines held low", {scl_oe, sda_oe}, 3);
        rd(2'd2, v); chk(v == 8'h08, "R7 done after start", v, 8'h08);
        chk(irq == 0, "R7 irq masked", irq, 0);
        wr(2'd2, 8'h08);
        rd(2'd2, v); chk(v == 8'h00, "R8 done cleared", v, 0);
        wr(2'd0, 8'h01);
    endtask

    task automatic t_byte(input logic [7:0] b, input logic ack, input logic use_irq);
        logic [7:0] v;
        clr_mon();
        ack_mode = ack;
        wr(2'd3, use_irq ? 8'h08 : 8'h00);
        wr(2'd1, b);
        wait_idle("R5");
        chk(rises == 9, "R5 nine SCL pulses", rises, 9);
        chk(cap[8:1] == b, "R5 byte MSB first", cap[8:1], b);
        chk(cap[0] == !ack, "R5 ninth-bit SDA", cap[0], !ack);
        chk(last_hi == 2 * Q, "R11 SCL high width", last_hi, 2 * Q);
        rd(2'd0, v); chk(v[3] == !ack, "R5 ack field", v[3], !ack);
        chk(irq == use_irq, "R7 irq follows enable", irq, use_irq);
        wr(2'd2, 8'h08);
        chk(irq == 0, "R7 irq drops with done", irq, 0);
    endtask

    task automatic t_busy_write();
        logic [7:0] v;
        clr_mon();
        ack_mode = 1'b1;
        wr(2'd1, 8'h5A);
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'h05);
        wait_idle("R9");
        chk(cap[8:1] == 8'h5A, "R9 busy write ignored", cap[8:1], 8'h5A);
        chk(stops == 0, "R9 busy stop ignored", stops, 0);
        rd(2'd2, v); chk(v == 8'h0C, "R9 error and done set", v, 8'h0C);
        wr(2'd2, 8'h60);
        rd(2'd2, v); chk(v == 8'h0C, "R8 reserved bits ignored", v, 8'h0C);
        wr(2'd2, 8'h04);
        rd(2'd2, v); chk(v == 8'h08, "R8 error alone cleared", v, 8'h08);
        wr(2'd2, 8'h08);
        rd(2'd2, v); chk(v == 8'h00, "R8 done cleared", v, 0);
    endtask

    task automatic t_rstart();
        logic [7:0] v;
        clr_mon();
        wr(2'd0, 8'h0B);
        wait_idle("R3");
        chk(starts == 1, "R3 repeated start seen", starts, 1);
        chk(rises == 1, "R3 one SCL rise", rises, 1);
        chk(scl_oe == 1 && sda_oe == 1, "R3 lines held low", {scl_oe, sda_oe}, 3);
        wr(2'd2, 8'h08);
        rd(2'd2, v); chk(v == 8'h00, "R3 status clean", v, 0);
    endtask

    task automatic t_stop();
        clr_mon();
        wr(2'd0, 8'h05);
        wait_idle("R4");
        chk(stops == 1, "R4 stop seen", stops, 1);
        chk(starts == 0, "R4 no start", starts, 0);
        chk(scl_oe == 0 && sda_oe == 0, "R4 lines released", {scl_oe, sda_oe}, 0);
        wr(2'd2, 8'h08);
        wr(2'd0, 8'h01);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_action();
        t_start();
        t_byte(8'hA5, 1'b1, 1'b1);
        t_byte(8'h3C, 1'b0, 1'b0);
        t_busy_write();
        t_rstart();
        t_byte(8'h81, 1'b1, 1'b0);
        t_stop();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end
endmodule